// File: doc/BRIEF.md
# Fully Associative Read Cache with Least-Recently-Used Replacement

This block sits between a processor load port and a slow, word-wide backing memory. It keeps a small number of entries, each a valid flag, an address tag and a block of one, two or four data words. A load presents a word-aligned 32-bit byte address. Every entry's tag is compared against that address in parallel. On a hit the word is returned in the same cycle the request is accepted. On a miss the block containing the word is fetched one word at a time over a request/acknowledge memory port, installed into a chosen entry, and the requested word is returned once the whole block has arrived.

The entry to fill is the lowest-numbered empty one while any remain. After that it is the entry that has gone longest without a reference, and hits count as references. Recency is kept as a rank per entry, 0 for the most recent and NUM_ENTRIES-1 for the least recent. The controller has three states. `ST_LOOKUP` accepts requests and serves hits. `ST_FETCH` streams the block in from memory. `ST_REPLY` presents the filled word for one cycle. The transitions are `ST_LOOKUP -> ST_FETCH` on an accepted miss, `ST_FETCH -> ST_FETCH` on each acknowledge that is not the last, `ST_FETCH -> ST_REPLY` on the last acknowledge, and `ST_REPLY -> ST_LOOKUP` unconditionally. There is no transition `ST_LOOKUP -> ST_LOOKUP` other than idling or serving a hit.

Top module: `fa_lru_cache`

## Requirements
- R1: After synchronous reset (`rst` high, active high) every entry is invalid, `req_ready` is 1, and `mem_req` and `rsp_valid` are 0. The recency ranks start as entry i having rank i.
- R2: A request accepted (`req_valid` and `req_ready` both 1) whose address is held in a valid entry raises `rsp_valid` in that same cycle, with `rsp_data` equal to the stored word.
- R3: An entry with a clear valid flag never produces a hit. An accepted miss gives no `rsp_valid` in its accepting cycle.
- R4: All tags are compared in parallel, and at most one entry matches a request.
- R5: From the cycle after an accepted miss until the reply cycle, `req_ready` is 0. `mem_req` stays 1 with a stable `mem_addr` until `mem_ack` is seen.
- R6: A miss fetches the aligned block. The first `mem_addr` is the request address with its low 2+log2(BLOCK_WORDS) bits cleared, and each later word is 4 bytes higher.
- R7: The cycle after the acknowledge of the last word of the block, `rsp_valid` is 1, `req_ready` is 0, and `rsp_data` is the requested word. The next cycle, `req_ready` is 1 again.
- R8: While any entry is invalid, a miss fills the lowest-numbered invalid entry, so no valid block is evicted before all entries hold data.
- R9: When all entries are valid, a miss replaces the least recently referenced block, where both hits and fills count as references.
- R10: BLOCK_WORDS may be 1, 2 or 4, which gives tags of 30, 29 or 28 bits. A miss performs exactly BLOCK_WORDS memory transfers, and every word of the filled block then hits.
- R11: With four one-word entries, byte addresses 4, 8, 16, 24, 8, 12, 16, 12 give miss, miss, miss, miss, hit, miss, hit, hit.
- R12: With two entries of two-word blocks, byte addresses 0, 12, 4, 8 give miss, miss, hit, hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Word-aligned byte address of the load |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Loaded word |
| mem_req | output | 1 | Backing memory word read request |
| mem_addr | output | ADDR_W | Byte address of the word being fetched |
| mem_ack | input | 1 | Backing memory returns a word this cycle |
| mem_data | input | DATA_W | Word returned by backing memory |

## Verification
The cache is tried in three shapes: four one-word entries, two two-word entries and four four-word entries. Each is checked against a recency-ordered list model of the resident blocks. The two short reference strings separate LRU from other victim choices, because the miss on 12 must evict the block holding 4, and they show that the neighbour word arrives with a two-word fill. A longer mixed string with repeats and conflicting blocks tells apart eviction on full capacity from eviction while empty entries remain. A run of four distinct blocks followed by revisiting all of them confirms that empty entries are used first. The fetch address sequence and the beat count on every miss confirm block alignment at each block size.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REPLY  = 2'd2
    } fsm_state_e;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int NUM_ENTRIES = 4,
    parameter int TAG_W       = 30,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TAG_W-1:0]       lookup_tag,
    input  logic                   install_en,
    input  logic [IDX_W-1:0]       install_idx,
    input  logic [TAG_W-1:0]       install_tag,
    output logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   hit_any,
    output logic [IDX_W-1:0]       hit_idx,
    output logic [NUM_ENTRIES-1:0] valid_vec
);

    logic [NUM_ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]       tag_q [NUM_ENTRIES];

    // one storage slot and one comparator per entry
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
            end else if (install_en && install_idx == IDX_W'(e)) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= install_tag;
            end
        end

        assign hit_vec[e] = valid_q[e] && (tag_q[e] == lookup_tag);
    end

    assign hit_any   = |hit_vec;
    assign valid_vec = valid_q;

    // encode the matching entry number
    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (hit_vec[e]) begin
                hit_idx = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/fa_lru_rank.sv
module fa_lru_rank #(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic                   touch_en,
    input  logic [IDX_W-1:0]       touch_idx,
    output logic [IDX_W-1:0]       victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENTRIES - 1);

    // rank 0 = most recently referenced, OLDEST = least recently referenced
    logic [IDX_W-1:0] rank_q [NUM_ENTRIES];
    logic [IDX_W-1:0] touched_rank;

    always_comb begin
        touched_rank = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (touch_idx == IDX_W'(e)) begin
                touched_rank = rank_q[e];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                rank_q[e] <= IDX_W'(e);
            end
        end else if (touch_en) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (touch_idx == IDX_W'(e)) begin
                    rank_q[e] <= '0;
                end else if (rank_q[e] < touched_rank) begin
                    rank_q[e] <= rank_q[e] + 1'b1;
                end
            end
        end
    end

    // lowest empty entry first, otherwise the oldest one
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (!valid_vec[e] && !found) begin
                victim_idx = IDX_W'(e);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (rank_q[e] == OLDEST) begin
                    victim_idx = IDX_W'(e);
                end
            end
        end
    end

endmodule

// File: rtl/fa_data_store.sv
module fa_data_store #(
    parameter int NUM_ENTRIES = 4,
    parameter int BLOCK_WORDS = 1,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 2,
    parameter int OFS_WS      = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_entry,
    input  logic [OFS_WS-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_entry,
    input  logic [OFS_WS-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] word_q [NUM_ENTRIES][BLOCK_WORDS];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        for (genvar w = 0; w < BLOCK_WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && wr_entry == IDX_W'(e) && wr_word == OFS_WS'(w)) begin
                    word_q[e][w] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int w = 0; w < BLOCK_WORDS; w++) begin
                if (rd_entry == IDX_W'(e) && rd_word == OFS_WS'(w)) begin
                    rd_data = word_q[e][w];
                end
            end
        end
    end

endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
    import fa_cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_ENTRIES = 4,
    parameter int BLOCK_WORDS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int OFS_W  = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 0;
    localparam int OFS_WS = (OFS_W > 0) ? OFS_W : 1;
    localparam int SHIFT  = 2 + OFS_W;
    localparam int TAG_W  = ADDR_W - SHIFT;
    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam logic [OFS_WS-1:0] LAST_WORD = OFS_WS'(BLOCK_WORDS - 1);

    fsm_state_e state_q, state_d;

    // request address split
    logic [ADDR_W-1:0] tag_shift, word_addr;
    logic [TAG_W-1:0]  req_tag;
    logic [OFS_WS-1:0] req_off;
    logic              unused_addr_bits;

    assign tag_shift = req_addr >> SHIFT;
    assign word_addr = req_addr >> 2;
    assign req_tag   = tag_shift[TAG_W-1:0];
    assign req_off   = word_addr[OFS_WS-1:0] & LAST_WORD;
    assign unused_addr_bits = ^{tag_shift[ADDR_W-1:TAG_W], word_addr[ADDR_W-1:OFS_WS], req_addr[1:0]};

    // miss context
    logic [TAG_W-1:0]  miss_tag_q;
    logic [OFS_WS-1:0] miss_off_q;
    logic [IDX_W-1:0]  victim_q;
    logic [OFS_WS-1:0] beat_q;

    logic [NUM_ENTRIES-1:0] hit_vec, valid_vec;
    logic                   hit_any;
    logic [IDX_W-1:0]       hit_idx, victim_idx;
    logic                   miss_start, hit_serve, fill_beat, fill_done, last_beat;
    logic                   touch_en;
    logic [IDX_W-1:0]       touch_idx, rd_entry;
    logic [OFS_WS-1:0]      rd_word;
    logic [DATA_W-1:0]      rd_data;

    assign last_beat  = (beat_q == LAST_WORD);
    assign hit_serve  = (state_q == ST_LOOKUP) && req_valid && hit_any;
    assign miss_start = (state_q == ST_LOOKUP) && req_valid && !hit_any;
    assign fill_beat  = (state_q == ST_FETCH) && mem_ack;
    assign fill_done  = fill_beat && last_beat;
    assign touch_en   = hit_serve || fill_done;
    assign touch_idx  = fill_done ? victim_q : hit_idx;
    assign rd_entry   = (state_q == ST_REPLY) ? victim_q : hit_idx;
    assign rd_word    = (state_q == ST_REPLY) ? miss_off_q : req_off;

    fa_tag_match #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .lookup_tag (req_tag),
        .install_en (fill_done),
        .install_idx(victim_q),
        .install_tag(miss_tag_q),
        .hit_vec    (hit_vec),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx),
        .valid_vec  (valid_vec)
    );

    fa_lru_rank #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W      (IDX_W)
    ) u_lru (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim_idx(victim_idx)
    );

    fa_data_store #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .BLOCK_WORDS(BLOCK_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .OFS_WS     (OFS_WS)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_beat),
        .wr_entry(victim_q),
        .wr_word (beat_q),
        .wr_data (mem_data),
        .rd_entry(rd_entry),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (req_valid && !hit_any) state_d = ST_FETCH;
            ST_FETCH:  if (mem_ack && last_beat)  state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_LOOKUP;
            default:   state_d = ST_LOOKUP;
        endcase
    end

    // miss context registers
    always_ff @(posedge clk) begin
        if (rst) begin
            miss_tag_q <= '0;
            miss_off_q <= '0;
            victim_q   <= '0;
            beat_q     <= '0;
        end else begin
            if (miss_start) begin
                miss_tag_q <= req_tag;
                miss_off_q <= req_off;
                victim_q   <= victim_idx;
                beat_q     <= '0;
            end else if (fill_beat) begin
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        rsp_data  = rd_data;
        mem_addr  = (ADDR_W'(miss_tag_q) << SHIFT) | (ADDR_W'(beat_q) << 2);
        unique case (state_q)
            ST_LOOKUP: begin
                req_ready = 1'b1;
                rsp_valid = req_valid && hit_any;
            end
            ST_FETCH:  mem_req   = 1'b1;
            ST_REPLY:  rsp_valid = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/fa_lru_cache_chk.sv
module fa_lru_cache_chk #(
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   rsp_valid,
    input logic                   mem_req,
    input logic                   mem_ack,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [NUM_ENTRIES-1:0] hit_vec,
    input logic                   fill_last
);

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R4

    AST_HIT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (|hit_vec)) |-> rsp_valid); // R2

    AST_MISS_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(|hit_vec)) |-> !rsp_valid); // R3

    AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(|hit_vec)) |=> (mem_req && !req_ready)); // R5

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5

    AST_FETCH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R5

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R6

    AST_REPLY_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && fill_last) |=> (rsp_valid && !req_ready && !mem_req)); // R7

endmodule

bind fa_lru_cache fa_lru_cache_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .hit_vec  (hit_vec),
    .fill_last(last_beat)
);

// File: tb/test_fa_lru_cache.sv
module cache_env #(
    parameter int NE   = 4,
    parameter int BW   = 1,
    parameter int SCEN = 0
) (
    input  logic clk,
    input  logic rst,
    output bit   done,
    output int   n_chk,
    output int   n_fail
);

    logic        req_valid = 1'b0;
    logic [31:0] req_addr  = '0;
    logic        req_ready, rsp_valid, mem_req;
    logic [31:0] rsp_data, mem_addr;
    logic        mem_ack  = 1'b0;
    logic [31:0] mem_data = '0;

    int          beat_cnt = 0;
    logic [31:0] exp_base = '0;
    int          lru_q[$];   // resident block numbers, most recent first

    fa_lru_cache #(
        .ADDR_W     (32),
        .DATA_W     (32),
        .NUM_ENTRIES(NE),
        .BLOCK_WORDS(BW)
    ) i_fa_lru_cache (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_data (mem_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s env%0d %s: actual %h expected %h", req, SCEN, what, act, exp);
        end
    endtask

    // backing memory: acknowledges every other cycle while requested
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            chk(mem_addr == exp_base + 32'(4 * beat_cnt), "R6", "fetch address",
                mem_addr, exp_base + 32'(4 * beat_cnt));
            beat_cnt++;
            mem_ack  = 1'b1;
            mem_data = memf(mem_addr);
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic access(input logic [31:0] a, input string lbl, output bit got_hit);
        int  blk;
        int  pos;
        bit  exp_hit;
        int  guard;
        blk = int'(a / (4 * BW));
        pos = -1;
        foreach (lru_q[i]) if (lru_q[i] == blk) pos = i;
        exp_hit = (pos >= 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 32'd1);
        got_hit = rsp_valid;
        chk(got_hit == exp_hit, lbl, "hit versus model", 32'(got_hit), 32'(exp_hit));
        if (got_hit) begin
            chk(rsp_data == memf(a), "R2", "hit data", rsp_data, memf(a));
        end else begin
            beat_cnt = 0;
            exp_base = a & ~32'(4 * BW - 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (!got_hit) begin
            guard = 0;
            while (!rsp_valid && guard < 100) begin
                chk(req_ready == 1'b0, "R5", "ready during fetch", 32'(req_ready), 32'd0);
                @(negedge clk);
                #1;
                guard++;
            end
            chk(rsp_valid == 1'b1, "R7", "reply after fill", 32'(rsp_valid), 32'd1);
            chk(rsp_data == memf(a), "R7", "filled word", rsp_data, memf(a));
            chk(beat_cnt == BW, "R10", "words per fill", 32'(beat_cnt), 32'(BW));
        end
        if (exp_hit) lru_q.delete(pos);
        else if (lru_q.size() == NE) void'(lru_q.pop_back());
        lru_q.push_front(blk);
    endtask

    task automatic run_list(input logic [31:0] lst[], input string lbl,
                            input bit use_pat, input bit pat[]);
        bit h;
        foreach (lst[i]) begin
            access(lst[i], lbl, h);
            if (use_pat) chk(h == pat[i], lbl, "fixed hit pattern", 32'(h), 32'(pat[i]));
        end
    endtask

    initial begin
        logic [31:0] long_s[] = '{8, 12, 44, 64, 84, 52, 256, 192, 76, 44, 12, 88, 16, 108, 24, 44};
        bit          none[];
        done   = 1'b0;
        n_chk  = 0;
        n_fail = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0, "R1", "no fetch after reset", 32'(mem_req), 32'd0);
        chk(rsp_valid == 1'b0, "R1", "no reply after reset", 32'(rsp_valid), 32'd0);
        if (SCEN == 0) begin
            run_list('{4, 8, 16, 24, 8, 12, 16, 12}, "R11", 1'b1, '{0, 0, 0, 0, 1, 0, 1, 1});
            run_list(long_s, "R9", 1'b0, none);
        end else if (SCEN == 1) begin
            run_list('{0, 12, 4, 8}, "R12", 1'b1, '{0, 0, 1, 1});
            run_list(long_s, "R9", 1'b0, none);
        end else begin
            // first access after reset must miss: R3
            run_list('{32'h100}, "R3", 1'b1, '{0});
            run_list('{32'h200, 32'h300, 32'h400}, "R8", 1'b1, '{0, 0, 0});
            run_list('{32'h10C, 32'h204, 32'h308, 32'h400}, "R8", 1'b1, '{1, 1, 1, 1});
            run_list(long_s, "R9", 1'b0, none);
            run_list('{32'h500, 32'h504, 32'h508, 32'h50C}, "R10", 1'b1, '{0, 1, 1, 1});
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

endmodule

module test_fa_lru_cache;

    logic clk = 1'b0;
    logic rst = 1'b1;
    bit   d0, d1, d2;
    int   c0, c1, c2, f0, f1, f2;

    always #5 clk = ~clk;

    cache_env #(.NE(4), .BW(1), .SCEN(0)) u_env0 (.clk(clk), .rst(rst), .done(d0), .n_chk(c0), .n_fail(f0));
    cache_env #(.NE(2), .BW(2), .SCEN(1)) u_env1 (.clk(clk), .rst(rst), .done(d1), .n_chk(c1), .n_fail(f1));
    cache_env #(.NE(4), .BW(4), .SCEN(2)) u_env2 (.clk(clk), .rst(rst), .done(d2), .n_chk(c2), .n_fail(f2));

    task automatic finish_run(input bit timed_out);
        int total;
        int failed;
        total  = c0 + c1 + c2;
        failed = f0 + f1 + f2;
        if (timed_out) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait (d0 && d1 && d2);
        finish_run(1'b0);
    end

    initial begin
        repeat (20000) @(posedge clk);
        finish_run(1'b1);
    end

endmodule